// File: doc/BRIEF.md
# Loadable Modulo-5 Toggle-Cell Counter

This block is a small synchronous counter whose state lives in a row of identical toggle cells, one per bit. Each cell holds its bit, inverts it when its toggle enable is high, loads an external bit when the write enable is high, and is forced to zero by a synchronous active-low clear. A shared carry network drives the toggle enables so that the four-bit register steps through 0, 1, 2, 3, 4 and then returns to 0.

Software or a neighbouring controller can preset the counter through the write enable and the load value. The load bypasses the modulus, so a value of 5 or more can be written. Such a value is held until the next counting clock, which returns the register to 0. When the count enable is low and neither load nor clear is active, the count holds.

Top module: `tcc_mod_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising clock edge, `count` is 0 after that edge, whatever `wr_en`, `ld_val` and `cnt_en` are.
- R2: When `clr_n` is 1 and `wr_en` is 1 at a rising edge, `count` equals `ld_val` after that edge, whatever `cnt_en` is. Values 0 to 15 are accepted unchanged.
- R3: When `clr_n` is 1, `wr_en` is 0, `cnt_en` is 1 and `count` is 0, 1, 2 or 3, `count` increases by exactly 1 at the edge.
- R4: When `clr_n` is 1, `wr_en` is 0, `cnt_en` is 1 and `count` is 4, `count` becomes 0 at the edge.
- R5: When `clr_n` is 1, `wr_en` is 0 and `cnt_en` is 0, `count` keeps its value at the edge. This includes loaded values of 5 to 15.
- R6: When `clr_n` is 1, `wr_en` is 0, `cnt_en` is 1 and `count` is 5 to 15, `count` becomes 0 at the edge.
- R7: Once the counter has been cleared and only counting has happened since, `count` never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes on the rising edge. |
| clr_n | input | 1 | Synchronous clear, active low. Has the highest priority. |
| wr_en | input | 1 | Load strobe. Takes priority over counting. |
| ld_val | input | 4 | Value written on a load. |
| cnt_en | input | 1 | Count enable. |
| count | output | 4 | Registered count value. |

## Verification
The step and range assertions assume that `cnt_en`, `wr_en` and `clr_n` are settled at each rising edge. The range assertion also assumes that no out-of-range value has been loaded since the last clear, so it is armed only by a clear and disarmed by any load. The bench changes its inputs only on falling edges. It clears before every check of the range. It sweeps all sixteen load values, with the count enable both low and high, and then free-runs and mixes clear with load to exercise the priorities.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CNT_W   = 4;
  localparam int CNT_MOD = 5;

  // control inputs seen by one toggle cell
  typedef struct packed {
    logic clr_n;
    logic we;
    logic te;
    logic d;
  } cell_ctl_t;
endpackage

// File: rtl/tcc_cell.sv
module tcc_cell (
  input  logic              clk,
  input  tcc_pkg::cell_ctl_t ctl,
  output logic              q
);
  always_ff @(posedge clk) begin
    if (!ctl.clr_n)   q <= 1'b0;
    else if (ctl.we)  q <= ctl.d;
    else if (ctl.te)  q <= ~q;
  end

  // the antecedent is only met at an edge that samples the clear, so this holds from time zero
  AST_CELL_CLEAR: assert property (@(posedge clk) !ctl.clr_n |=> q == 1'b0); // R1
  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!ctl.clr_n)
    (!ctl.we && !ctl.te) |=> $stable(q)); // R5
endmodule

// File: rtl/tcc_carry.sv
module tcc_carry #(
  parameter int WIDTH   = tcc_pkg::CNT_W,
  parameter int MODULUS = tcc_pkg::CNT_MOD
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             cnt_en,
  output logic [WIDTH-1:0] te
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic             wrap;
  logic [WIDTH:0]   low_ones;

  // wrap covers the last legal value and anything above it (reachable only by a load)
  assign wrap        = (cnt >= LAST);
  assign low_ones[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_te
    assign low_ones[i+1] = low_ones[i] & cnt[i];
    // at wrap, toggling every set bit returns the register to zero
    assign te[i] = cnt_en & (wrap ? cnt[i] : low_ones[i]);
  end
endmodule

// File: rtl/tcc_mod_counter.sv
module tcc_mod_counter #(
  parameter int WIDTH   = tcc_pkg::CNT_W,
  parameter int MODULUS = tcc_pkg::CNT_MOD
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             cnt_en,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] te;
  logic [WIDTH-1:0] q;

  tcc_carry #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_carry (
    .cnt    (q),
    .cnt_en (cnt_en),
    .te     (te)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    tcc_pkg::cell_ctl_t ctl;
    assign ctl = '{clr_n: clr_n, we: wr_en, te: te[i], d: ld_val[i]};
    tcc_cell u_cell (
      .clk (clk),
      .ctl (ctl),
      .q   (q[i])
    );
  end

  assign count = q;

  // set by a clear, dropped by a load: marks that the count came only from counting
  logic in_range;
  always_ff @(posedge clk) begin
    if (!clr_n)     in_range <= 1'b1;
    else if (wr_en) in_range <= 1'b0;
  end

  AST_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
    wr_en |=> count == $past(ld_val)); // R2
  AST_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_en && cnt_en && count < LAST) |=> count == $past(count) + 1'b1); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_en && cnt_en && count >= LAST) |=> count == '0); // R4 R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_en && !cnt_en) |=> $stable(count)); // R5
  AST_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
    in_range |-> count <= LAST); // R7
endmodule

// File: tb/sim_tcc_mod_counter.sv
`timescale 1ns/1ps
module sim_tcc_mod_counter;
  logic       clk = 1'b0;
  logic       clr_n, wr_en, cnt_en;
  logic [3:0] ld_val;
  logic [3:0] count;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcc_mod_counter u0 (
    .clk(clk), .clr_n(clr_n), .wr_en(wr_en),
    .ld_val(ld_val), .cnt_en(cnt_en), .count(count)
  );

  function automatic logic [3:0] model_next(logic [3:0] c, logic en);
    if (!en) return c;
    return (c >= 4'd4) ? 4'd0 : c + 4'd1;
  endfunction

  task automatic check(string req, logic [3:0] exp);
    n_chk++;
    if (count !== exp) begin
      n_bad++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  // apply inputs on the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic tick(logic c, logic w, logic [3:0] v, logic e);
    clr_n = c; wr_en = w; ld_val = v; cnt_en = e;
    @(negedge clk);
  endtask

  initial begin
    clr_n = 1'b0; wr_en = 1'b0; ld_val = 4'd0; cnt_en = 1'b0;
    @(negedge clk);
    tick(1'b0, 1'b1, 4'd9, 1'b1);
    check("R1 reset state", 4'd0);

    // every load value, then hold and count from it
    for (int v = 0; v < 16; v++) begin
      tick(1'b1, 1'b1, 4'(v), 1'b1);
      check("R2 load", 4'(v));
      tick(1'b1, 1'b0, 4'hF, 1'b0);
      check("R5 hold after load", 4'(v));
      tick(1'b1, 1'b0, 4'hF, 1'b1);
      if (v >= 5) check("R6 out of range to zero", 4'd0);
      else if (v == 4) check("R4 wrap", 4'd0);
      else check("R3 step", 4'(v + 1));
    end

    // clear beats load, from every start value
    for (int v = 0; v < 16; v++) begin
      tick(1'b1, 1'b1, 4'(v), 1'b0);
      tick(1'b0, 1'b1, 4'hA, 1'b1);
      check("R1 clear over load", 4'd0);
    end

    // free run with a varying enable pattern
    begin
      logic [3:0] exp;
      tick(1'b0, 1'b0, 4'd0, 1'b0);
      exp = 4'd0;
      for (int k = 0; k < 60; k++) begin
        logic en;
        en = ((k % 7) != 3);
        tick(1'b1, 1'b0, 4'(k), en);
        exp = model_next(exp, en);
        if (!en) check("R5 hold", exp);
        else check("R3 R4 run", exp);
        n_chk++;
        if (count > 4'd4) begin
          n_bad++;
          $display("FAIL R7: count=%0d expected<=4", count);
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: count=%0d expected=finish", count);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule